// File: doc/BRIEF.md
# External Clock Failure Monitor

This block watches an external crystal clock from a separate internal reference clock. It raises an alarm when the crystal clock stops. Software turns the monitor on, but the monitor arms only while the crystal oscillator is enabled and reports ready. Arming therefore waits out the oscillator startup delay. Arming ends whenever the crystal is stopped.

The monitor detects a failure with a toggle flop in the monitored domain. The toggle flop's output is synchronised into the reference domain and turned into an edge strobe. A counter measures how many reference cycles pass with no edge. If 16 consecutive reference cycles pass with no edge while the monitor is armed, a failure is declared.

On a failure the block does four things:
- It sets a pending flag that feeds the non-maskable interrupt. The flag stays set until software writes 1 to the clear input.
- It pulses a break event to the timers.
- It pulses a command that disables the crystal.
- It decides on the system clock fallback. If the crystal drives the system clock, either directly or through the PLL, it requests an emergency switch to the internal RC clock. If the PLL is involved, it also disables the PLL.

After a failure, the monitor stays disarmed until the crystal is stopped and then enabled again.

Top module: `ext_clk_fail_mon`

## Requirements
- R1: After reset, irq_o, brk_o, xtal_off_o, pll_off_o and rc_switch_o are all 0.
- R2: While armed, a monitored clock whose edges reach the reference domain at least every few reference cycles never causes a failure. In the test, the monitored clock has a 20 ns period against an 8 ns reference period.
- R3: The monitor is armed only while mon_en_i, xtal_on_i and xtal_rdy_i are all 1. If any of them is 0, a stopped monitored clock produces no irq_o and no brk_o.
- R4: A failure is declared once MISS_LIMIT (default 16) consecutive armed reference cycles pass without a synchronised edge. The synchroniser adds a few cycles on top of this. As a result, irq_o rises no earlier than 12 and no later than 35 reference cycles after the monitored clock stops.
- R5: Each failure gives exactly one brk_o pulse, one reference cycle wide.
- R6: Each failure gives exactly one single-cycle xtal_off_o pulse, in the same cycle as brk_o.
- R7: irq_o rises together with brk_o and stays 1 until a cycle in which clr_i is 1. In the cycle after that, it reads 0.
- R8: sys_sel_i encodes the system clock source as 2'b00 for the internal RC, 2'b01 for the crystal and 2'b10 for the PLL.
  - With 2'b01, a failure gives one rc_switch_o pulse and no pll_off_o.
  - With 2'b00, a failure gives neither.
- R9: With sys_sel_i equal to 2'b10 and pll_src_xtal_i equal to 1, a failure gives one rc_switch_o pulse and one pll_off_o pulse. With sys_sel_i equal to 2'b10 and pll_src_xtal_i equal to 0, it gives neither.
- R10: After a failure, the monitor stays disarmed, with no further brk_o, while xtal_on_i remains 1. Once xtal_on_i has been 0 and the crystal is enabled and ready again, a new stop is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Internal reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mon_clk_i | input | 1 | Crystal clock being watched |
| mon_en_i | input | 1 | Software enable of the monitor |
| xtal_on_i | input | 1 | Crystal oscillator enabled |
| xtal_rdy_i | input | 1 | Crystal startup delay completed |
| sys_sel_i | input | 2 | Current system clock source (00 RC, 01 crystal, 10 PLL) |
| pll_src_xtal_i | input | 1 | PLL input is the crystal, divided or not |
| clr_i | input | 1 | Write-1-to-clear of the pending failure flag |
| irq_o | output | 1 | Failure pending, drives the non-maskable interrupt |
| brk_o | output | 1 | Single-cycle break event to timers |
| xtal_off_o | output | 1 | Single-cycle crystal disable command |
| pll_off_o | output | 1 | Single-cycle PLL disable command |
| rc_switch_o | output | 1 | Single-cycle request to switch system clock to the RC |

## Verification
The monitored clock is tried in three ways:
- Running freely while armed, to separate real stops from the normal gaps between synchronised edges.
- Stopped while each of the three arming conditions is held low, to show that each one gates detection on its own.
- Stopped while armed, so that the response latency can be checked against the 16-cycle window.

Failures are repeated under each system clock source and PLL input combination, which distinguishes the fallback decode for every case. A stop that persists after a failure, followed by a crystal off/on cycle, separates the post-failure lockout from re-arming.

// File: rtl/cfm_pkg.sv
`timescale 1ns/1ps
package cfm_pkg;
  typedef enum logic [1:0] {
    SYS_RC   = 2'b00,
    SYS_XTAL = 2'b01,
    SYS_PLL  = 2'b10
  } sys_src_e;
endpackage

// File: rtl/cfm_edge_sync.sv
`timescale 1ns/1ps
module cfm_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic mon_clk_i,
  input  logic ref_clk_i,
  input  logic rst_ni,
  output logic edge_o
);
  localparam int SW = SYNC_STAGES + 1;

  logic          tgl_q;
  logic [SW-1:0] sync_q;

  // toggle in monitored domain, one transition per monitored edge
  always_ff @(posedge mon_clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= 1'b0;
    else         tgl_q <= ~tgl_q;
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SW-2:0], tgl_q};
  end

  assign edge_o = sync_q[SW-1] ^ sync_q[SW-2];
endmodule

// File: rtl/cfm_miss_counter.sv
`timescale 1ns/1ps
module cfm_miss_counter #(
  parameter int MISS_LIMIT = 16
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic arm_req_i,
  input  logic xtal_on_i,
  output logic fail_evt_o
);
  localparam int CW = $clog2(MISS_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(MISS_LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          lock_q;
  logic          armed;

  assign armed      = arm_req_i && !lock_q;
  assign fail_evt_o = armed && !edge_i && (cnt_q == LAST);

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!armed || edge_i) cnt_q <= '0;
    else if (fail_evt_o)       cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // lockout after a failure until the crystal is stopped
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)         lock_q <= 1'b0;
    else if (fail_evt_o) lock_q <= 1'b1;
    else if (!xtal_on_i) lock_q <= 1'b0;
  end

  // R3
  no_unarmed_fail_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !arm_req_i |-> !fail_evt_o);
  // R10
  lock_hold_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    fail_evt_o |=> !fail_evt_o);
  // R4
  cnt_bound_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    cnt_q < CW'(MISS_LIMIT));
endmodule

// File: rtl/cfm_response.sv
`timescale 1ns/1ps
module cfm_response
  import cfm_pkg::*;
(
  input  logic       ref_clk_i,
  input  logic       rst_ni,
  input  logic       fail_evt_i,
  input  logic       clr_i,
  input  logic [1:0] sys_sel_i,
  input  logic       pll_src_xtal_i,
  output logic       irq_o,
  output logic       brk_o,
  output logic       xtal_off_o,
  output logic       pll_off_o,
  output logic       rc_switch_o
);
  sys_src_e src;
  logic     via_pll, direct;

  assign src     = sys_src_e'(sys_sel_i);
  assign direct  = (src == SYS_XTAL);
  assign via_pll = (src == SYS_PLL) && pll_src_xtal_i;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o       <= 1'b0;
      brk_o       <= 1'b0;
      xtal_off_o  <= 1'b0;
      pll_off_o   <= 1'b0;
      rc_switch_o <= 1'b0;
    end else begin
      irq_o       <= fail_evt_i | (irq_o & ~clr_i);
      brk_o       <= fail_evt_i;
      xtal_off_o  <= fail_evt_i;
      pll_off_o   <= fail_evt_i & via_pll;
      rc_switch_o <= fail_evt_i & (direct | via_pll);
    end
  end

  // R5
  brk_single_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    brk_o |=> !brk_o);
  // R6
  brk_xoff_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    brk_o |-> xtal_off_o);
  // R7
  irq_hold_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    irq_o && !clr_i |=> irq_o);
  // R7
  irq_with_brk_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    brk_o |-> irq_o);
  // R9
  pll_off_sw_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    pll_off_o |-> rc_switch_o);
endmodule

// File: rtl/ext_clk_fail_mon.sv
`timescale 1ns/1ps
module ext_clk_fail_mon #(
  parameter int MISS_LIMIT  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       ref_clk_i,
  input  logic       rst_ni,
  input  logic       mon_clk_i,
  input  logic       mon_en_i,
  input  logic       xtal_on_i,
  input  logic       xtal_rdy_i,
  input  logic [1:0] sys_sel_i,
  input  logic       pll_src_xtal_i,
  input  logic       clr_i,
  output logic       irq_o,
  output logic       brk_o,
  output logic       xtal_off_o,
  output logic       pll_off_o,
  output logic       rc_switch_o
);
  logic edge_s, fail_evt;

  cfm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .mon_clk_i (mon_clk_i),
    .ref_clk_i (ref_clk_i),
    .rst_ni    (rst_ni),
    .edge_o    (edge_s)
  );

  cfm_miss_counter #(.MISS_LIMIT(MISS_LIMIT)) u_cnt (
    .ref_clk_i  (ref_clk_i),
    .rst_ni     (rst_ni),
    .edge_i     (edge_s),
    .arm_req_i  (mon_en_i && xtal_on_i && xtal_rdy_i),
    .xtal_on_i  (xtal_on_i),
    .fail_evt_o (fail_evt)
  );

  cfm_response u_rsp (
    .ref_clk_i      (ref_clk_i),
    .rst_ni         (rst_ni),
    .fail_evt_i     (fail_evt),
    .clr_i          (clr_i),
    .sys_sel_i      (sys_sel_i),
    .pll_src_xtal_i (pll_src_xtal_i),
    .irq_o          (irq_o),
    .brk_o          (brk_o),
    .xtal_off_o     (xtal_off_o),
    .pll_off_o      (pll_off_o),
    .rc_switch_o    (rc_switch_o)
  );
endmodule

// File: tb/ext_clk_fail_mon_test.sv
`timescale 1ns/1ps
module ext_clk_fail_mon_test;
  logic ref_clk = 0, mon_clk = 0, rst_n = 0, mon_run = 0;
  logic mon_en = 0, xtal_on = 0, xtal_rdy = 0, psrc = 0, clr = 0;
  logic [1:0] sys_sel = 2'b00;
  logic irq, brk, xoff, poff, rcsw;
  int n_chk = 0, n_err = 0;

  ext_clk_fail_mon uut (
    .ref_clk_i(ref_clk), .rst_ni(rst_n), .mon_clk_i(mon_clk),
    .mon_en_i(mon_en), .xtal_on_i(xtal_on), .xtal_rdy_i(xtal_rdy),
    .sys_sel_i(sys_sel), .pll_src_xtal_i(psrc), .clr_i(clr),
    .irq_o(irq), .brk_o(brk), .xtal_off_o(xoff), .pll_off_o(poff),
    .rc_switch_o(rcsw)
  );

  always #4 ref_clk = ~ref_clk;
  always begin
    #10;
    if (mon_run) mon_clk = ~mon_clk;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic rearm();
    xtal_on = 0; xtal_rdy = 0; cyc(3);
    mon_run = 1; xtal_on = 1; cyc(2);
    xtal_rdy = 1; mon_en = 1; cyc(30);
  endtask

  // stop monitored clock and count responses over a window
  task automatic stop_watch(output int nb, output int nx, output int np, output int ns,
                            output int irq_at);
    nb = 0; nx = 0; np = 0; ns = 0; irq_at = -1;
    mon_run = 0;
    for (int i = 0; i < 45; i++) begin
      @(negedge ref_clk);
      nb += int'(brk); nx += int'(xoff); np += int'(poff); ns += int'(rcsw);
      if (irq && irq_at < 0) irq_at = i;
    end
  endtask

  task automatic t_reset();
    cyc(2);
    chk("R1", "reset outputs", {irq, brk, xoff, poff, rcsw}, 0);
  endtask

  task automatic t_running();
    int nb = 0;
    rearm();
    for (int i = 0; i < 300; i++) begin
      @(negedge ref_clk);
      nb += int'(brk);
    end
    chk("R2", "running clock brk count", nb, 0);
    chk("R2", "running clock irq", irq, 0);
  endtask

  task automatic t_unarmed(input int which);
    int nb, nx, np, ns, ia;
    rearm();
    if (which == 0) mon_en = 0;
    if (which == 1) xtal_rdy = 0;
    if (which == 2) xtal_on = 0;
    stop_watch(nb, nx, np, ns, ia);
    chk("R3", $sformatf("unarmed(%0d) brk count", which), nb, 0);
    chk("R3", $sformatf("unarmed(%0d) irq", which), irq, 0);
    mon_en = 1; xtal_on = 1; xtal_rdy = 1;
  endtask

  task automatic t_fail(input logic [1:0] sel, input logic ps, input int exp_sw,
                        input int exp_pll, input string req);
    int nb, nx, np, ns, ia;
    sys_sel = sel; psrc = ps;
    rearm();
    stop_watch(nb, nx, np, ns, ia);
    chk("R4", "irq latency in 12..35", int'(ia >= 12 && ia <= 35), 1);
    chk("R5", "brk pulses", nb, 1);
    chk("R6", "xtal_off pulses", nx, 1);
    chk(req, "rc_switch pulses", ns, exp_sw);
    chk(req, "pll_off pulses", np, exp_pll);
    cyc(20);
    chk("R7", "irq held without clear", irq, 1);
    clr = 1; cyc(1); clr = 0; cyc(1);
    chk("R7", "irq after clear", irq, 0);
  endtask

  task automatic t_lockout();
    int nb, nx, np, ns, ia;
    t_fail(2'b00, 1'b0, 0, 0, "R8");
    stop_watch(nb, nx, np, ns, ia);
    chk("R10", "no brk while locked", nb, 0);
    chk("R10", "no irq while locked", irq, 0);
    rearm();
    stop_watch(nb, nx, np, ns, ia);
    chk("R10", "brk after re-enable", nb, 1);
    clr = 1; cyc(1); clr = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    t_reset();
    t_running();
    t_unarmed(0);
    t_unarmed(1);
    t_unarmed(2);
    t_fail(2'b00, 1'b1, 0, 0, "R8");
    t_fail(2'b01, 1'b0, 1, 0, "R8");
    t_fail(2'b10, 1'b1, 1, 1, "R9");
    t_fail(2'b10, 1'b0, 0, 0, "R9");
    t_lockout();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule